// File: doc/BRIEF.md
# Ping-Pong Frame Capture Controller

This block takes pixels from a parallel video port and stores whole frames into two frame-sized regions of memory, alternating between them. The first frame goes to buffer 0, the next to buffer 1, then back to buffer 0, and so on. When a frame completes, the block raises a one-cycle interrupt carrying the buffer index. That buffer then belongs to the consumer until the consumer releases it.

A frame is never written into a buffer the consumer still holds. If the buffer next in line has not been released when a frame begins, the whole frame is discarded and a saturating drop counter advances. A frame-start marker always restarts writing at offset 0 of the current buffer, so a truncated frame is simply overwritten. By default a buffer holds one 352x288 frame of 16-bit 4:2:2 samples, one word per pixel. Buffer 0 starts at address 0 and buffer 1 starts at address FRAME_W*FRAME_H.

Top module: `pp_frame_capture`

## Requirements
- R1: During and right after reset, mem_we, irq, fill_buf, ready_mask and drop_count are all 0.
- R2: An accepted frame's valid pixels are written in arrival order: the pixel that carries frame_start goes to offset 0, and each later valid pixel goes to the next offset, up to offset FRAME_W*FRAME_H-1. Cycles without pix_valid write nothing.
- R3: Buffer 0 occupies addresses 0 to N-1 and buffer 1 occupies N to 2N-1, with N = FRAME_W*FRAME_H. Filling starts in buffer 0, and each completed frame switches fill_buf to the other buffer.
- R4: The cycle in which the last write of a frame appears on the memory port also shows the following: irq is high for exactly that one cycle, irq_buf carries the completed buffer's index, that buffer's ready_mask bit is 1, and fill_buf names the other buffer.
- R5: A frame whose frame_start arrives while ready_mask[fill_buf] is 1 is dropped. It produces no writes and no irq, drop_count increments by one, and fill_buf is unchanged.
- R6: drop_count saturates at 2^CNT_W-1.
- R7: A cycle with release_valid high clears ready_mask[release_buf] from the next cycle on. Releasing a buffer whose bit is already 0 has no effect.
- R8: A frame_start during a frame restarts writing at offset 0 of the same buffer. Only the frame that completes raises irq.
- R9: Valid pixels outside a frame (before any frame_start, after a frame completes, or during a dropped frame) produce no write.
- R10: Each write appears on mem_we, mem_addr and mem_wdata in the cycle after the pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present on pix_data this cycle |
| frame_start | input | 1 | Marks the valid pixel as the first of a frame |
| pix_data | input | PIX_W | Pixel sample |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | PIX_W | Memory write data |
| irq | output | 1 | One-cycle frame-complete pulse |
| irq_buf | output | 1 | Buffer index that completed |
| release_valid | input | 1 | Consumer hands a buffer back |
| release_buf | input | 1 | Index of the buffer being released |
| fill_buf | output | 1 | Buffer the next or current frame fills |
| ready_mask | output | 2 | Per-buffer flag: full and held by consumer |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
The assertions assume that pix_valid, frame_start, release_valid and release_buf are never unknown once reset has been released. They also assume that frame_start is only meaningful together with pix_valid. Under those conditions, no write may land in a buffer that was flagged ready before the write, and every interrupt must coincide with a write and a set ready bit. The stimulus drives all inputs on the falling edge with defined values and raises frame_start only alongside pix_valid. It holds release_valid for exactly one cycle per release, so each release event can be tied to a single cycle.

// File: rtl/pp_capture_pkg.sv
package pp_capture_pkg;
    localparam int NUM_BUF = 2;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_WRITE = 2'd1,
        CAP_DROP  = 2'd2
    } cap_mode_e;
endpackage

// File: rtl/pp_write_seq.sv
// Offset sequencer: decides per pixel whether it is written, where, and
// whether it closes or abandons a frame.
module pp_write_seq
    import pp_capture_pkg::*;
#(
    parameter int FRAME_WORDS = 8,
    parameter int OFF_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             frame_start,
    input  logic             target_busy,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_off,
    output logic             frame_done,
    output logic             drop_evt
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(FRAME_WORDS - 1);
    localparam bit               ONE_WORD = (FRAME_WORDS == 1);

    typedef struct packed {
        cap_mode_e        mode;
        logic [OFF_W-1:0] off;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        wr_en      = 1'b0;
        wr_off     = s_q.off;
        frame_done = 1'b0;
        drop_evt   = 1'b0;
        if (pix_valid && frame_start) begin
            if (target_busy) begin
                drop_evt = 1'b1;
                s_d.mode = CAP_DROP;
                s_d.off  = '0;
            end else begin
                wr_en  = 1'b1;
                wr_off = '0;
                if (ONE_WORD) begin
                    frame_done = 1'b1;
                    s_d.mode   = CAP_IDLE;
                    s_d.off    = '0;
                end else begin
                    s_d.mode = CAP_WRITE;
                    s_d.off  = OFF_W'(1);
                end
            end
        end else if (pix_valid && s_q.mode == CAP_WRITE) begin
            wr_en = 1'b1;
            if (s_q.off == LAST_OFF) begin
                frame_done = 1'b1;
                s_d.mode   = CAP_IDLE;
                s_d.off    = '0;
            end else begin
                s_d.off = s_q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode <= CAP_IDLE;
            s_q.off  <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pp_buf_owner.sv
// Tracks which buffer is being filled and which buffers the consumer holds.
module pp_buf_owner
    import pp_capture_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done,
    input  logic               release_valid,
    input  logic               release_buf,
    output logic               fill_buf,
    output logic [NUM_BUF-1:0] ready
);
    typedef struct packed {
        logic               fill;
        logic [NUM_BUF-1:0] ready;
    } own_t;

    own_t o_q, o_d;

    always_comb begin
        o_d = o_q;
        for (int b = 0; b < NUM_BUF; b++) begin
            if (release_valid && release_buf == 1'(b))
                o_d.ready[b] = 1'b0;
            if (frame_done && o_q.fill == 1'(b))
                o_d.ready[b] = 1'b1;
        end
        if (frame_done)
            o_d.fill = ~o_q.fill;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.fill  <= 1'b0;
            o_q.ready <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign fill_buf = o_q.fill;
    assign ready    = o_q.ready;
endmodule

// File: rtl/pp_sat_counter.sv
module pp_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/pp_frame_capture.sv
module pp_frame_capture
    import pp_capture_pkg::*;
#(
    parameter int FRAME_W = 352,
    parameter int FRAME_H = 288,
    parameter int PIX_W   = 16,
    parameter int CNT_W   = 8,
    localparam int FRAME_WORDS = FRAME_W * FRAME_H,
    localparam int OFF_W  = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
    localparam int ADDR_W = $clog2(NUM_BUF * FRAME_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               frame_start,
    input  logic [PIX_W-1:0]   pix_data,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [PIX_W-1:0]   mem_wdata,
    output logic               irq,
    output logic               irq_buf,
    input  logic               release_valid,
    input  logic               release_buf,
    output logic               fill_buf,
    output logic [NUM_BUF-1:0] ready_mask,
    output logic [CNT_W-1:0]   drop_count
);
    localparam logic [ADDR_W-1:0] BUF1_BASE = ADDR_W'(FRAME_WORDS);

    logic             wr_en, frame_done, drop_evt, cur_fill;
    logic [OFF_W-1:0] wr_off;
    logic [NUM_BUF-1:0] ready;

    pp_write_seq #(
        .FRAME_WORDS(FRAME_WORDS),
        .OFF_W      (OFF_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .frame_start(frame_start),
        .target_busy(ready[cur_fill]),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .frame_done (frame_done),
        .drop_evt   (drop_evt)
    );

    pp_buf_owner u_own (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (frame_done),
        .release_valid(release_valid),
        .release_buf  (release_buf),
        .fill_buf     (cur_fill),
        .ready        (ready)
    );

    pp_sat_counter #(
        .CNT_W(CNT_W)
    ) u_drop (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (drop_evt),
        .count(drop_count)
    );

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [PIX_W-1:0]  data;
        logic              irq;
        logic              irq_buf;
    } wport_t;

    wport_t w_q, w_d;

    always_comb begin
        w_d.we      = wr_en;
        w_d.addr    = (cur_fill ? BUF1_BASE : '0) + ADDR_W'(wr_off);
        w_d.data    = pix_data;
        w_d.irq     = frame_done;
        w_d.irq_buf = frame_done ? cur_fill : w_q.irq_buf;
        if (!wr_en) begin
            w_d.addr = w_q.addr;
            w_d.data = w_q.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign mem_we     = w_q.we;
    assign mem_addr   = w_q.addr;
    assign mem_wdata  = w_q.data;
    assign irq        = w_q.irq;
    assign irq_buf    = w_q.irq_buf;
    assign fill_buf   = cur_fill;
    assign ready_mask = ready;
endmodule

// File: rtl/pp_capture_chk.sv
module pp_capture_chk #(
    parameter int FRAME_WORDS = 8,
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq,
    input logic              irq_buf,
    input logic              release_valid,
    input logic              release_buf,
    input logic              fill_buf,
    input logic [1:0]        ready_mask,
    input logic [CNT_W-1:0]  drop_count
);
    logic       wbuf;
    logic [1:0] wsel;
    assign wbuf = 32'(mem_addr) >= 32'(FRAME_WORDS);
    assign wsel = wbuf ? 2'b10 : 2'b01;

    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> 32'(mem_addr) < 32'(2 * FRAME_WORDS));

    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (($past(ready_mask) & wsel) == 2'b00));

    p_irq_marks_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready_mask[irq_buf] && fill_buf != irq_buf));

    p_irq_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mem_we);

    p_drop_monotonic_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count >= $past(drop_count));

    p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_valid |=> (!ready_mask[$past(release_buf)] ||
                           (irq && irq_buf == $past(release_buf))));
endmodule

bind pp_frame_capture pp_capture_chk #(
    .FRAME_WORDS(FRAME_WORDS),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .irq          (irq),
    .irq_buf      (irq_buf),
    .release_valid(release_valid),
    .release_buf  (release_buf),
    .fill_buf     (fill_buf),
    .ready_mask   (ready_mask),
    .drop_count   (drop_count)
);

// File: tb/pp_frame_capture_test.sv
`timescale 1ns/1ps
module pp_frame_capture_test;
    localparam int FW     = 4;
    localparam int FH     = 2;
    localparam int NW     = FW * FH;
    localparam int PW     = 16;
    localparam int CW     = 3;
    localparam int AW     = $clog2(2 * NW);
    localparam int CMAX   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0, frame_start = 1'b0;
    logic [PW-1:0] pix_data = '0;
    logic          mem_we, irq, irq_buf, fill_buf;
    logic [AW-1:0] mem_addr;
    logic [PW-1:0] mem_wdata;
    logic          release_valid = 1'b0, release_buf = 1'b0;
    logic [1:0]    ready_mask;
    logic [CW-1:0] drop_count;

    always #4 clk = ~clk;

    pp_frame_capture #(.FRAME_W(FW), .FRAME_H(FH), .PIX_W(PW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
        .pix_data(pix_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq(irq), .irq_buf(irq_buf), .release_valid(release_valid),
        .release_buf(release_buf), .fill_buf(fill_buf), .ready_mask(ready_mask),
        .drop_count(drop_count));

    int tests = 0, fails = 0;
    int wr_cnt = 0, irq_cnt = 0, irq_bad = 0;
    logic last_irq_buf = 1'b0;
    logic [PW-1:0] mem [2*NW];
    bit done = 0;

    // Monitor on the falling edge: outputs are stable there.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (irq) begin
                irq_cnt <= irq_cnt + 1;
                last_irq_buf <= irq_buf;
                if (!mem_we || !ready_mask[irq_buf] || fill_buf == irq_buf)
                    irq_bad <= irq_bad + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_px(logic [PW-1:0] d, logic st);
        @(negedge clk);
        pix_valid = 1'b1; frame_start = st; pix_data = d;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        pix_valid = 1'b0; frame_start = 1'b0; release_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(int base, int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                pix_valid = 1'b0; frame_start = 1'b0;
            end
            send_px(PW'(base + i), i == 0);
        end
        idle(2);
    endtask

    task automatic release_one(logic b);
        @(negedge clk);
        release_valid = 1'b1; release_buf = b;
        idle(1);
    endtask

    task automatic check_buf(string req, int b, int base);
        for (int i = 0; i < NW; i++)
            check(req, int'(mem[b*NW + i]), base + i);
    endtask

    initial begin
        for (int i = 0; i < 2*NW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 we", int'(mem_we), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 fill", int'(fill_buf), 0);
        check("R1 ready", int'(ready_mask), 0);
        check("R1 drop", int'(drop_count), 0);
        rst_n = 1'b1;
        idle(1);
        check("R1 after reset ready", int'(ready_mask), 0);

        // R9: pixels with no frame_start are not written
        for (int i = 0; i < 3; i++) send_px(PW'(16'h0EE0 + i), 1'b0);
        idle(2);
        check("R9 no frame", wr_cnt, 0);

        // R2/R3/R4: first frame into buffer 0, back to back
        send_frame(16'h0100, NW, 1'b0);
        check("R4 irq count", irq_cnt, 1);
        check("R4 irq buf", int'(last_irq_buf), 0);
        check("R4 ready", int'(ready_mask), 1);
        check("R3 fill toggles", int'(fill_buf), 1);
        check("R2 writes", wr_cnt, NW);
        check_buf("R2 buf0 data", 0, 16'h0100);

        // R9: trailing pixels after completion
        send_px(16'h0DDD, 1'b0); send_px(16'h0DDE, 1'b0);
        idle(2);
        check("R9 trailing", wr_cnt, NW);

        // R2/R3: second frame with gaps into buffer 1
        send_frame(16'h0200, NW, 1'b1);
        check("R3 irq buf", int'(last_irq_buf), 1);
        check("R3 ready", int'(ready_mask), 3);
        check("R3 fill back", int'(fill_buf), 0);
        check_buf("R2 buf1 gapped", 1, 16'h0200);

        // R5: both held -> frame dropped
        send_frame(16'h0300, NW, 1'b0);
        check("R5 no writes", wr_cnt, 2*NW);
        check("R5 drop", int'(drop_count), 1);
        check("R5 no irq", irq_cnt, 2);
        check("R5 fill same", int'(fill_buf), 0);
        check_buf("R5 buf0 kept", 0, 16'h0100);

        // R7 release of buf1 only; R5 target buf0 still held
        release_one(1'b1);
        check("R7 release 1", int'(ready_mask), 1);
        send_frame(16'h0400, NW, 1'b0);
        check("R5 drop again", int'(drop_count), 2);
        check_buf("R5 buf1 kept", 1, 16'h0200);

        // R7: release buf0, release it again (no effect)
        release_one(1'b0);
        check("R7 release 0", int'(ready_mask), 0);
        release_one(1'b0);
        check("R7 double release", int'(ready_mask), 0);
        send_frame(16'h0500, NW, 1'b0);
        check("R3 buf0 again", int'(last_irq_buf), 0);
        check("R3 fill 1", int'(fill_buf), 1);
        check_buf("R2 buf0 new", 0, 16'h0500);

        // R8: truncated frame restarted by frame_start
        send_px(16'h0600, 1'b1); send_px(16'h0601, 1'b0); send_px(16'h0602, 1'b0);
        send_frame(16'h0700, NW, 1'b0);
        check("R8 one irq", irq_cnt, 4);
        check("R8 irq buf", int'(last_irq_buf), 1);
        check_buf("R8 buf1 restart", 1, 16'h0700);
        check("R8 ready", int'(ready_mask), 3);

        // R6: saturation
        for (int k = 0; k < 8; k++) begin
            send_px(16'h0999, 1'b1);
            idle(0);
        end
        idle(1);
        check("R6 saturate", int'(drop_count), CMAX);

        // R9: pixels during dropped frame
        send_px(16'h0AAA, 1'b0);
        idle(1);
        check("R9 dropped frame", wr_cnt, 4*NW + 3);

        // R10: write appears the cycle after the pixel
        release_one(1'b0);
        @(negedge clk);
        pix_valid = 1'b1; frame_start = 1'b1; pix_data = 16'h0800;
        check("R10 before edge", int'(mem_we), 0);
        @(negedge clk);
        check("R10 we", int'(mem_we), 1);
        check("R10 addr", int'(mem_addr), 0);
        check("R10 data", int'(mem_wdata), 16'h0800);
        frame_start = 1'b0;
        for (int i = 1; i < NW; i++) begin
            pix_data = PW'(16'h0800 + i);
            @(negedge clk);
        end
        idle(2);
        check_buf("R10 buf0", 0, 16'h0800);
        check("R4 irq pulses consistent", irq_bad, 0);
        check("R4 irq total", irq_cnt, 5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule